// File: doc/BRIEF.md
# Dual-Window Heartbeat Watchdog

This block watches a heartbeat signal driven by processor software and requests a system reset when that signal stops changing for too long. It uses two window lengths. A long boot window applies after every reset event, so that a slow boot does not trip it. The first heartbeat change seen inside that boot window switches the block to a short running window. A change counts as a kick whether the heartbeat rises or falls.

The heartbeat must already be synchronized to `clk`. `sys_rst` is the level of the system reset that the external reset generator drives. While it is high, the timer is cleared and held. When it is released, the block starts in boot mode. `rst_evt` is a one-cycle strobe that marks any other reset event and restarts the boot window. When a window runs out, `expire` pulses for one cycle towards the reset generator. The block then stays silent until `sys_rst` has been asserted and released.

The state machine has five states:

| State | Behaviour |
|-------|-----------|
| HOLD | Reset held, timer cleared |
| BOOT | Long window |
| RUN | Short window |
| FIRE | One-cycle expiry pulse |
| HALT | Spent, waiting for reset |

Its transitions are:

- reset-asserted: any state to HOLD.
- release: HOLD to BOOT.
- first-kick: BOOT to RUN.
- event-restart: BOOT or RUN to BOOT.
- kick: RUN to RUN, with the timer cleared.
- timeout: BOOT or RUN to FIRE.
- spent: FIRE to HALT.

The window lengths are `BOOT_CYCLES/TIME_DIV` and `RUN_CYCLES/TIME_DIV` clock cycles, using integer division. BL and RL below name these two values.

Top module: `dual_window_watchdog`

## Requirements
- R1: Let E0 be the first rising edge that samples `rst_n` high and `sys_rst` low after a reset. If no heartbeat change follows, `expire` is high in the cycle after edge E0+BL.
- R2: The first heartbeat change in boot mode switches the block to the short window. A change is a value at an edge that differs from the value at the previous edge. A change sampled at edge E0+BL still counts, and expiry then follows at that edge plus RL. A change sampled one edge later comes too late: expiry happens at E0+BL.
- R3: In running mode, every rising and every falling heartbeat change restarts the window. With no further change, `expire` rises after edge T+RL, where T is the edge of the last change.
- R4: `expire` is high for exactly one cycle. After it, heartbeat changes and `rst_evt` produce no further pulse until `sys_rst` has been asserted and released.
- R5: While `sys_rst` is high, `expire` stays low whatever the heartbeat and `rst_evt` do. Release always restarts boot mode with the long window, even if the block was in running mode before.
- R6: A `rst_evt` strobe sampled at edge S, with `sys_rst` low in boot or running mode, restarts boot mode. With no heartbeat change after it, expiry happens at S+BL.
- R7: When `rst_evt` and a heartbeat change are sampled at the same edge, `rst_evt` wins and the long window applies.
- R8: A heartbeat pulse only one clock cycle wide counts as two changes: the rise and the fall.
- R9: The window lengths are `BOOT_CYCLES/TIME_DIV` and `RUN_CYCLES/TIME_DIV` clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; its period must be shorter than the narrowest heartbeat pulse |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | System reset level from the reset generator; holds the timer clear |
| rst_evt | input | 1 | One-cycle strobe marking a reset event; restarts the boot window |
| hb | input | 1 | Synchronized heartbeat from software |
| expire | output | 1 | One-cycle pulse requesting a reset |

## Verification
The bench aims at the edge of the boot window. A kick landing exactly on the last boot cycle must switch the block to running mode. A kick one cycle later must not. An off-by-one compare would move the expiry by a cycle or miss it entirely. Single-cycle pulses show whether both heartbeat directions are counted: a design that only counts rising edges expires one cycle early. The bench also checks the priority of `rst_evt` over a heartbeat change in the same cycle, that release after running mode goes back to the long window, and that the block stays silent after expiry. A design that kept counting would emit repeated pulses.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    typedef enum logic [2:0] {
        WD_HOLD = 3'd0,
        WD_BOOT = 3'd1,
        WD_RUN  = 3'd2,
        WD_FIRE = 3'd3,
        WD_HALT = 3'd4
    } wd_state_e;

    function automatic int cnt_bits(input longint unsigned limit);
        return (limit < 64'd2) ? 1 : $clog2(limit + 64'd1);
    endfunction

endpackage

// File: rtl/wdw_edge.sv
module wdw_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic hb,
    output logic kick
);
    logic hb_q;

    // previous heartbeat sample; a difference from the present value is a kick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hb_q <= 1'b0;
        end else begin
            hb_q <= hb;
        end
    end

    assign kick = hb ^ hb_q;

endmodule

// File: rtl/wdw_timer.sv
module wdw_timer #(
    parameter int               CNT_W    = 8,
    parameter logic [CNT_W-1:0] BOOT_END = '1,
    parameter logic [CNT_W-1:0] RUN_END  = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic long_sel,
    output logic hit
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] end_val;

    assign end_val = long_sel ? BOOT_END : RUN_END;
    assign hit     = run && (cnt == end_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R3: while the short window runs the count never passes its end
    p_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !long_sel) |-> (cnt <= RUN_END));

    // R1: while the long window runs the count never passes its end
    p_boot_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && long_sel) |-> (cnt <= BOOT_END));

endmodule

// File: rtl/wdw_fsm.sv
module wdw_fsm
    import wdw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sys_rst,
    input  logic      rst_evt,
    input  logic      kick,
    input  logic      hit,
    output wd_state_e state,
    output logic      cnt_clr,
    output logic      cnt_run,
    output logic      long_sel,
    output logic      expire
);
    wd_state_e nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WD_HOLD;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        if (sys_rst) begin
            nxt = WD_HOLD;                       // reset-asserted
        end else begin
            unique case (state)
                WD_HOLD: nxt = WD_BOOT;          // release
                WD_BOOT: begin
                    if (rst_evt)   nxt = WD_BOOT;  // event-restart
                    else if (kick) nxt = WD_RUN;   // first-kick
                    else if (hit)  nxt = WD_FIRE;  // timeout
                end
                WD_RUN: begin
                    if (rst_evt)   nxt = WD_BOOT;  // event-restart
                    else if (kick) nxt = WD_RUN;   // kick
                    else if (hit)  nxt = WD_FIRE;  // timeout
                end
                WD_FIRE: nxt = WD_HALT;          // spent
                WD_HALT: nxt = WD_HALT;
                default: nxt = WD_HOLD;
            endcase
        end
    end

    // outputs
    always_comb begin
        cnt_clr  = 1'b1;
        cnt_run  = 1'b0;
        long_sel = 1'b0;
        expire   = 1'b0;
        unique case (state)
            WD_BOOT: begin
                cnt_run  = 1'b1;
                long_sel = 1'b1;
                cnt_clr  = sys_rst | rst_evt | kick;
            end
            WD_RUN: begin
                cnt_run  = 1'b1;
                cnt_clr  = sys_rst | rst_evt | kick;
            end
            WD_FIRE: expire = 1'b1;
            WD_HOLD, WD_HALT: cnt_clr = 1'b1;
            default: cnt_clr = 1'b1;
        endcase
    end

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

    p_halt_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_HALT && !sys_rst) |=> !expire);

    p_quiet_in_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> (!expire && state == WD_HOLD));

    p_boot_after_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_HOLD && !sys_rst) |=> (state == WD_BOOT));

endmodule

// File: rtl/dual_window_watchdog.sv
module dual_window_watchdog
    import wdw_pkg::*;
#(
    parameter longint unsigned BOOT_CYCLES = 64'd10_800_000_000,
    parameter longint unsigned RUN_CYCLES  = 64'd336_000_000,
    parameter longint unsigned TIME_DIV    = 64'd1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_rst,
    input  logic rst_evt,
    input  logic hb,
    output logic expire
);
    localparam longint unsigned BOOT_LIM = BOOT_CYCLES / TIME_DIV;
    localparam longint unsigned RUN_LIM  = RUN_CYCLES / TIME_DIV;
    localparam int              CNT_W    = cnt_bits(BOOT_LIM);
    localparam logic [CNT_W-1:0] BOOT_END = CNT_W'(BOOT_LIM - 64'd1);
    localparam logic [CNT_W-1:0] RUN_END  = CNT_W'(RUN_LIM - 64'd1);

    logic      kick;
    logic      hit;
    logic      cnt_clr;
    logic      cnt_run;
    logic      long_sel;
    wd_state_e state;

    wdw_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .hb    (hb),
        .kick  (kick)
    );

    wdw_timer #(
        .CNT_W    (CNT_W),
        .BOOT_END (BOOT_END),
        .RUN_END  (RUN_END)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .run      (cnt_run),
        .long_sel (long_sel),
        .hit      (hit)
    );

    wdw_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_rst  (sys_rst),
        .rst_evt  (rst_evt),
        .kick     (kick),
        .hit      (hit),
        .state    (state),
        .cnt_clr  (cnt_clr),
        .cnt_run  (cnt_run),
        .long_sel (long_sel),
        .expire   (expire)
    );

    // a heartbeat change inside a window always prevents the next-cycle pulse
    p_kick_blocks_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !sys_rst && (state == WD_BOOT || state == WD_RUN)) |=> !expire);

    // the first change in boot moves to the running window unless an event wins
    p_first_kick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !sys_rst && !rst_evt && state == WD_BOOT) |=> (state == WD_RUN));

    // an event strobe always lands in boot mode (R6, R7)
    p_event_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_evt && !sys_rst && (state == WD_BOOT || state == WD_RUN)) |=> (state == WD_BOOT && !expire));

endmodule

// File: tb/dual_window_watchdog_bench.sv
`timescale 1ns/1ps
module dual_window_watchdog_bench;
    localparam longint unsigned BOOT_C = 64'd12000;
    localparam longint unsigned RUN_C  = 64'd1500;
    localparam longint unsigned DIV    = 64'd10;
    localparam int BL = int'(BOOT_C / DIV);
    localparam int RL = int'(RUN_C / DIV);

    logic clk = 1'b0;
    logic rst_n, sys_rst, rst_evt, hb;
    logic expire;

    always #2.5 clk = ~clk;

    dual_window_watchdog #(
        .BOOT_CYCLES (BOOT_C),
        .RUN_CYCLES  (RUN_C),
        .TIME_DIV    (DIV)
    ) u_dual_window_watchdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .sys_rst (sys_rst),
        .rst_evt (rst_evt),
        .hb      (hb),
        .expire  (expire)
    );

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int exp_total = 0;
    int exp_last = -1;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // sample the output 1 ns after each rising edge
    always begin
        @(posedge clk);
        #1;
        if (expire === 1'b1) begin
            exp_total = exp_total + 1;
            exp_last = cyc;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    function automatic int due(input int clear_edge, input int lim);
        return clear_edge + lim;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggle(output int at);
        hb = ~hb;
        at = cyc + 1;
    endtask

    task automatic restart(output int e0);
        sys_rst = 1'b1;
        step(3);
        sys_rst = 1'b0;
        e0 = cyc + 1;
    endtask

    task automatic expect_one(input int base, input int when, input string req, input string what);
        while (cyc < when + 5) step(1);
        check((exp_total - base) == 1, req, {what, " pulse count"}, exp_total - base, 1);
        check(exp_last == when, req, {what, " expiry edge"}, exp_last, when);
    endtask

    initial begin
        int e0, t, s, b, gap;
        void'($urandom(32'd7391));
        rst_n = 1'b0; sys_rst = 1'b0; rst_evt = 1'b0; hb = 1'b0;
        step(4);
        check(expire == 1'b0, "R5", "expire in reset", expire, 0);

        // R1 / R9: long window after power-up
        b = exp_total;
        rst_n = 1'b1;
        e0 = cyc + 1;
        step(BL / 2);
        check(exp_total == b, "R1", "no expiry mid boot", exp_total - b, 0);
        expect_one(b, due(e0, BL), "R1", "boot timeout");
        check((exp_last - e0) == 1200, "R9", "boot window length", exp_last - e0, 1200);

        // R4: spent block ignores heartbeat and event strobe
        b = exp_total;
        for (int i = 0; i < 10; i++) begin toggle(t); step(3); end
        rst_evt = 1'b1; step(1); rst_evt = 1'b0;
        step(BL + RL);
        check(exp_total == b, "R4", "silent after expiry", exp_total - b, 0);

        // R5: reset from running mode returns to the long window
        restart(e0);
        step(5); toggle(t); step(10);
        sys_rst = 1'b1;
        b = exp_total;
        for (int i = 0; i < 40; i++) begin toggle(t); step(7); end
        rst_evt = 1'b1; step(1); rst_evt = 1'b0;
        step(BL + 10);
        check(exp_total == b, "R5", "held in reset", exp_total - b, 0);
        sys_rst = 1'b0;
        e0 = cyc + 1;
        expect_one(b, due(e0, BL), "R5", "long window after release");

        // R2 / R3 / R8: random kicks in running mode
        restart(e0);
        b = exp_total;
        step(400);
        toggle(t); step(1);
        for (int i = 0; i < 30; i++) begin
            gap = int'($urandom_range(RL - 1, 1));
            if ($urandom_range(3, 0) == 0) begin
                toggle(t); step(1); toggle(t); step(gap);
            end else begin
                toggle(t); step(gap);
            end
        end
        expect_one(b, due(t, RL), "R3", "random kicks then stop");

        // R2: kick at the last boot edge still counts
        restart(e0);
        b = exp_total;
        step(e0 + BL - 1 - cyc);
        toggle(t); step(1);
        check(t == e0 + BL, "R2", "kick edge placement", t, e0 + BL);
        expect_one(b, due(t, RL), "R2", "kick on last boot edge");

        // R2: kick one edge late does not count
        restart(e0);
        b = exp_total;
        step(e0 + BL - cyc);
        toggle(t); step(1);
        expect_one(b, due(e0, BL), "R2", "kick one edge late");
        step(RL + 10);
        check((exp_total - b) == 1, "R4", "no second pulse", exp_total - b, 1);

        // R8: one-cycle pulse gives two kicks
        restart(e0);
        step(20);
        b = exp_total;
        toggle(t); step(30);
        toggle(t); step(1); toggle(t); step(1);
        expect_one(b, due(t, RL), "R8", "narrow pulse");

        // R6: event strobe in running mode restarts the long window
        restart(e0);
        step(10); toggle(t); step(50);
        b = exp_total;
        rst_evt = 1'b1; s = cyc + 1; step(1); rst_evt = 1'b0;
        expect_one(b, due(s, BL), "R6", "event restart");

        // R7: event and heartbeat change on the same edge
        restart(e0);
        step(30);
        b = exp_total;
        rst_evt = 1'b1; toggle(t); s = t; step(1); rst_evt = 1'b0;
        expect_one(b, due(s, BL), "R7", "event beats kick");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule